// File: doc/BRIEF.md
# Trap Entry Controller

This block takes a single-cycle trap strobe from the pipeline, together with the cause code, an interrupt flag, the faulting address and the pc of the trapping instruction. On the clock edge that samples the strobe it picks the handling level (machine or supervisor), pushes the interrupt-enable and privilege stack for that level, writes that level's cause, exception pc and trap value registers, switches the privilege and drops any outstanding load reservation. In the same cycle it drives the redirect pc, taken from the selected level's trap vector register, with a per-cause offset when the vector register asks for vectored interrupts.

An environment-call exception arrives as code 8 and is renamed by the current privilege before it is routed or recorded. Delegation and vector registers, the status word and the privilege are loaded through a plain write port for setup; trap entry wins over that port in a shared cycle.

Top module: `trap_entry_ctrl`

## Requirements
- R1: After reset the privilege is machine (3), status_o is zero, all cause, epc and tval outputs are zero and resv_o is low.
- R2: A trap is handled at supervisor level exactly when the current privilege is user (0) or supervisor (1), the (renamed) code is below XLEN, and the bit at that code is set in the interrupt delegation register for interrupts or the exception delegation register for exceptions; every other trap, including any trap taken in machine mode, is handled at machine level.
- R3: Machine entry sets status bit 3 (machine prior enable) to the old bit 1 (machine enable), bits 6:5 (machine prior privilege) to the old privilege, clears bit 1, writes m_epc_o with trap_pc_i and sets the privilege to 3; supervisor cause, epc and tval are unchanged.
- R4: Supervisor entry sets status bit 2 (supervisor prior enable) to the old bit 0 (supervisor enable), bit 4 (supervisor prior privilege) to bit 0 of the old privilege, clears bit 0, writes s_epc_o with trap_pc_i and sets the privilege to 1; machine cause, epc and tval are unchanged.
- R5: The written cause register holds the code in its low CODE_W bits, bit XLEN-1 equal to the interrupt flag and zero elsewhere.
- R6: While trap_valid_i is high, redirect_o is high and next_pc_o is the selected level's vector register with bits 1:0 cleared, plus 4 times the code when that register's bits 1:0 equal 1 and the trap is an interrupt.
- R7: The written tval is trap_addr_i only for exceptions with code 0, 1, 4, 5, 6, 7, 12, 13 or 15; for every other exception and for all interrupts it is zero.
- R8: An exception with code 8 is recorded and routed as 8 from user, 9 from supervisor and 11 from machine.
- R9: resv_set_i raises resv_o on the next edge; a trap clears it on its edge, also when resv_set_i is high in that cycle.
- R10: The write port selects by wr_sel_i: 0 status, 1 exception delegation, 2 interrupt delegation, 3 machine vector, 4 supervisor vector, 5 privilege; a privilege write of 2 stores 0, and a trap in the same cycle overrides the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_valid_i | input | 1 | Trap strobe, one cycle per trap |
| trap_irq_i | input | 1 | 1 for interrupt, 0 for exception |
| trap_code_i | input | CODE_W | Raw cause code |
| trap_addr_i | input | XLEN | Faulting address |
| trap_pc_i | input | XLEN | pc of the trapping instruction |
| resv_set_i | input | 1 | Sets the load reservation |
| wr_en_i | input | 1 | Setup write enable |
| wr_sel_i | input | 3 | Setup register select |
| wr_data_i | input | XLEN | Setup write data |
| redirect_o | output | 1 | pc redirect strobe |
| next_pc_o | output | XLEN | Handler pc |
| priv_o | output | 2 | Current privilege |
| status_o | output | 7 | Enable and privilege stack |
| m_cause_o | output | XLEN | Machine cause |
| m_epc_o | output | XLEN | Machine exception pc |
| m_tval_o | output | XLEN | Machine trap value |
| s_cause_o | output | XLEN | Supervisor cause |
| s_epc_o | output | XLEN | Supervisor exception pc |
| s_tval_o | output | XLEN | Supervisor trap value |
| resv_o | output | 1 | Load reservation held |

## Verification
A wrong routing decision shows in the same cycle as a next_pc_o taken from the other vector register, and one edge later as the privilege, status stack and cause landing on the wrong side while the other side's epc changes. A stale privilege or enable bit shows only at the following trap, through the pushed prior fields, so the vectors chain traps from each privilege with the status rewritten before each one. Renaming and tval capture errors appear one edge after the strobe in the cause and tval outputs.

// File: rtl/trap_pkg.sv
package trap_pkg;
   localparam logic [1:0] PRIV_U = 2'd0;
   localparam logic [1:0] PRIV_S = 2'd1;
   localparam logic [1:0] PRIV_M = 2'd3;

   localparam int unsigned ECALL_BASE = 8;

   typedef enum logic [2:0] {
      SEL_STATUS = 3'd0,
      SEL_EDELEG = 3'd1,
      SEL_IDELEG = 3'd2,
      SEL_MVEC   = 3'd3,
      SEL_SVEC   = 3'd4,
      SEL_PRIV   = 3'd5
   } wr_sel_e;

   typedef struct packed {
      logic [1:0] m_pp;
      logic       s_pp;
      logic       m_pie;
      logic       s_pie;
      logic       m_ie;
      logic       s_ie;
   } status_t;

   function automatic logic addr_bearing(input int unsigned code);
      case (code)
         0, 1, 4, 5, 6, 7, 12, 13, 15: addr_bearing = 1'b1;
         default:                      addr_bearing = 1'b0;
      endcase
   endfunction
endpackage

// File: rtl/trap_route.sv
module trap_route
   import trap_pkg::*;
#(
   parameter int unsigned XLEN   = 32,
   parameter int unsigned CODE_W = 6
) (
   input  logic [1:0]        priv_i,
   input  logic              irq_i,
   input  logic [CODE_W-1:0] code_i,
   input  logic [XLEN-1:0]   edeleg_i,
   input  logic [XLEN-1:0]   ideleg_i,
   output logic [CODE_W-1:0] code_o,
   output logic              to_s_o,
   output logic              keep_tval_o
);
   localparam int unsigned IDX_W = $clog2(XLEN);

   logic [XLEN-1:0] deleg_vec;
   logic            in_range;

   always_comb begin
      code_o = code_i;
      if (!irq_i && code_i == CODE_W'(ECALL_BASE)) begin
         case (priv_i)
            PRIV_S:  code_o = CODE_W'(ECALL_BASE + 1);
            PRIV_M:  code_o = CODE_W'(ECALL_BASE + 3);
            default: code_o = CODE_W'(ECALL_BASE);
         endcase
      end
   end

   assign deleg_vec   = irq_i ? ideleg_i : edeleg_i;
   assign in_range    = (32'(code_o) < XLEN);
   assign to_s_o      = (priv_i != PRIV_M) && in_range && deleg_vec[code_o[IDX_W-1:0]];
   assign keep_tval_o = !irq_i && addr_bearing(32'(code_o));
endmodule

// File: rtl/trap_vector.sv
module trap_vector #(
   parameter int unsigned XLEN     = 32,
   parameter int unsigned CODE_W   = 6,
   parameter bit          VECTORED = 1'b1
) (
   input  logic [XLEN-1:0]   tvec_i,
   input  logic              irq_i,
   input  logic [CODE_W-1:0] code_i,
   output logic [XLEN-1:0]   pc_o
);
   logic [XLEN-1:0] base;
   assign base = {tvec_i[XLEN-1:2], 2'b00};

   generate
      if (VECTORED) begin : g_vec
         logic [XLEN-1:0] offs;
         assign offs = {{(XLEN-CODE_W-2){1'b0}}, code_i, 2'b00};
         assign pc_o = (irq_i && tvec_i[1:0] == 2'b01) ? base + offs : base;
      end else begin : g_direct
         logic unused_sig;
         assign unused_sig = irq_i ^ (^code_i) ^ (^tvec_i[1:0]);
         assign pc_o = base;
      end
   endgenerate
endmodule

// File: rtl/trap_csr.sv
module trap_csr
   import trap_pkg::*;
#(
   parameter int unsigned XLEN   = 32,
   parameter int unsigned CODE_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              trap_valid_i,
   input  logic              irq_i,
   input  logic [CODE_W-1:0] code_i,
   input  logic              to_s_i,
   input  logic              keep_tval_i,
   input  logic [XLEN-1:0]   addr_i,
   input  logic [XLEN-1:0]   pc_i,
   input  logic              resv_set_i,
   input  logic              wr_en_i,
   input  logic [2:0]        wr_sel_i,
   input  logic [XLEN-1:0]   wr_data_i,
   output logic [1:0]        priv_o,
   output status_t           status_o,
   output logic [XLEN-1:0]   edeleg_o,
   output logic [XLEN-1:0]   ideleg_o,
   output logic [XLEN-1:0]   mvec_o,
   output logic [XLEN-1:0]   svec_o,
   output logic [XLEN-1:0]   m_cause_o,
   output logic [XLEN-1:0]   m_epc_o,
   output logic [XLEN-1:0]   m_tval_o,
   output logic [XLEN-1:0]   s_cause_o,
   output logic [XLEN-1:0]   s_epc_o,
   output logic [XLEN-1:0]   s_tval_o,
   output logic              resv_o
);
   logic [XLEN-1:0] cause_val;
   logic [XLEN-1:0] tval_val;

   assign cause_val = {irq_i, {(XLEN-1-CODE_W){1'b0}}, code_i};
   assign tval_val  = keep_tval_i ? addr_i : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         priv_o    <= PRIV_M;
         status_o  <= '0;
         edeleg_o  <= '0;
         ideleg_o  <= '0;
         mvec_o    <= '0;
         svec_o    <= '0;
         m_cause_o <= '0;
         m_epc_o   <= '0;
         m_tval_o  <= '0;
         s_cause_o <= '0;
         s_epc_o   <= '0;
         s_tval_o  <= '0;
      end else if (trap_valid_i) begin
         if (to_s_i) begin
            status_o.s_pie <= status_o.s_ie;
            status_o.s_pp  <= priv_o[0];
            status_o.s_ie  <= 1'b0;
            s_epc_o        <= pc_i;
            s_cause_o      <= cause_val;
            s_tval_o       <= tval_val;
            priv_o         <= PRIV_S;
         end else begin
            status_o.m_pie <= status_o.m_ie;
            status_o.m_pp  <= priv_o;
            status_o.m_ie  <= 1'b0;
            m_epc_o        <= pc_i;
            m_cause_o      <= cause_val;
            m_tval_o       <= tval_val;
            priv_o         <= PRIV_M;
         end
      end else if (wr_en_i) begin
         case (wr_sel_i)
            SEL_STATUS: status_o <= status_t'(wr_data_i[6:0]);
            SEL_EDELEG: edeleg_o <= wr_data_i;
            SEL_IDELEG: ideleg_o <= wr_data_i;
            SEL_MVEC:   mvec_o   <= wr_data_i;
            SEL_SVEC:   svec_o   <= wr_data_i;
            SEL_PRIV:   priv_o   <= (wr_data_i[1:0] == 2'd2) ? PRIV_U : wr_data_i[1:0];
            default:    ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)            resv_o <= 1'b0;
      else if (trap_valid_i) resv_o <= 1'b0;
      else if (resv_set_i)   resv_o <= 1'b1;
   end

   // R3
   m_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trap_valid_i && !to_s_i |=> priv_o == PRIV_M && !status_o.m_ie && $stable(s_epc_o));
   // R4
   s_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trap_valid_i && to_s_i |=> priv_o == PRIV_S && !status_o.s_ie && $stable(m_epc_o));
   // R7
   tval_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trap_valid_i && !keep_tval_i && !to_s_i |=> m_tval_o == '0);
   // R9
   resv_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trap_valid_i |=> !resv_o);
   // R10
   priv_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      priv_o != 2'd2);
endmodule

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl
   import trap_pkg::*;
#(
   parameter int unsigned XLEN     = 32,
   parameter int unsigned CODE_W   = 6,
   parameter bit          VECTORED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              trap_valid_i,
   input  logic              trap_irq_i,
   input  logic [CODE_W-1:0] trap_code_i,
   input  logic [XLEN-1:0]   trap_addr_i,
   input  logic [XLEN-1:0]   trap_pc_i,
   input  logic              resv_set_i,
   input  logic              wr_en_i,
   input  logic [2:0]        wr_sel_i,
   input  logic [XLEN-1:0]   wr_data_i,
   output logic              redirect_o,
   output logic [XLEN-1:0]   next_pc_o,
   output logic [1:0]        priv_o,
   output logic [6:0]        status_o,
   output logic [XLEN-1:0]   m_cause_o,
   output logic [XLEN-1:0]   m_epc_o,
   output logic [XLEN-1:0]   m_tval_o,
   output logic [XLEN-1:0]   s_cause_o,
   output logic [XLEN-1:0]   s_epc_o,
   output logic [XLEN-1:0]   s_tval_o,
   output logic              resv_o
);
   localparam int unsigned IDX_W = $clog2(XLEN);

   generate
      if (XLEN != 32 && XLEN != 64) begin : g_bad_xlen
         $error("trap_entry_ctrl: XLEN must be 32 or 64");
      end
      if (CODE_W < IDX_W || CODE_W + 2 >= XLEN) begin : g_bad_code
         $error("trap_entry_ctrl: CODE_W out of range for XLEN");
      end
   endgenerate

   logic [CODE_W-1:0] eff_code;
   logic              to_s;
   logic              keep_tval;
   logic [XLEN-1:0]   edeleg, ideleg, mvec, svec;
   status_t           status;

   trap_route #(.XLEN(XLEN), .CODE_W(CODE_W)) route_i (
      .priv_i      (priv_o),
      .irq_i       (trap_irq_i),
      .code_i      (trap_code_i),
      .edeleg_i    (edeleg),
      .ideleg_i    (ideleg),
      .code_o      (eff_code),
      .to_s_o      (to_s),
      .keep_tval_o (keep_tval)
   );

   trap_vector #(.XLEN(XLEN), .CODE_W(CODE_W), .VECTORED(VECTORED)) vec_i (
      .tvec_i (to_s ? svec : mvec),
      .irq_i  (trap_irq_i),
      .code_i (eff_code),
      .pc_o   (next_pc_o)
   );

   trap_csr #(.XLEN(XLEN), .CODE_W(CODE_W)) csr_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .trap_valid_i (trap_valid_i),
      .irq_i        (trap_irq_i),
      .code_i       (eff_code),
      .to_s_i       (to_s),
      .keep_tval_i  (keep_tval),
      .addr_i       (trap_addr_i),
      .pc_i         (trap_pc_i),
      .resv_set_i   (resv_set_i),
      .wr_en_i      (wr_en_i),
      .wr_sel_i     (wr_sel_i),
      .wr_data_i    (wr_data_i),
      .priv_o       (priv_o),
      .status_o     (status),
      .edeleg_o     (edeleg),
      .ideleg_o     (ideleg),
      .mvec_o       (mvec),
      .svec_o       (svec),
      .m_cause_o    (m_cause_o),
      .m_epc_o      (m_epc_o),
      .m_tval_o     (m_tval_o),
      .s_cause_o    (s_cause_o),
      .s_epc_o      (s_epc_o),
      .s_tval_o     (s_tval_o),
      .resv_o       (resv_o)
   );

   assign status_o   = status;
   assign redirect_o = trap_valid_i;
endmodule

// File: tb/trap_entry_ctrl_tb_top.sv
module trap_entry_ctrl_tb_top;
   localparam int XLEN = 32;
   localparam int CW   = 6;
   localparam logic [31:0] MVEC = 32'h0000_1001;
   localparam logic [31:0] SVEC = 32'h0000_2003;
   localparam int NV = 12;
   // fields: priv(2) irq(1) code(6) to_s(1) eff_code(6) capture(1)
   localparam logic [16:0] VEC [NV] = '{
      {2'd0, 1'b0, 6'd2,  1'b1, 6'd2,  1'b0},
      {2'd1, 1'b0, 6'd13, 1'b1, 6'd13, 1'b1},
      {2'd3, 1'b0, 6'd13, 1'b0, 6'd13, 1'b1},
      {2'd0, 1'b0, 6'd8,  1'b1, 6'd8,  1'b0},
      {2'd1, 1'b0, 6'd8,  1'b0, 6'd9,  1'b0},
      {2'd3, 1'b0, 6'd8,  1'b0, 6'd11, 1'b0},
      {2'd0, 1'b1, 6'd5,  1'b1, 6'd5,  1'b0},
      {2'd1, 1'b1, 6'd7,  1'b0, 6'd7,  1'b0},
      {2'd0, 1'b0, 6'd0,  1'b0, 6'd0,  1'b1},
      {2'd0, 1'b0, 6'd15, 1'b0, 6'd15, 1'b1},
      {2'd1, 1'b0, 6'd3,  1'b0, 6'd3,  1'b0},
      {2'd0, 1'b1, 6'd40, 1'b0, 6'd40, 1'b0}
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic trap_valid = 0, trap_irq = 0, resv_set = 0, wr_en = 0;
   logic [CW-1:0] trap_code = '0;
   logic [31:0] trap_addr = '0, trap_pc = '0, wr_data = '0;
   logic [2:0] wr_sel = '0;
   logic redirect, resv;
   logic [31:0] next_pc, m_cause, m_epc, m_tval, s_cause, s_epc, s_tval;
   logic [1:0] priv;
   logic [6:0] status;
   int errors = 0, checks = 0;

   always #10 clk = ~clk;

   trap_entry_ctrl #(.XLEN(XLEN), .CODE_W(CW)) dut_i (
      .clk(clk), .rst_n(rst_n), .trap_valid_i(trap_valid), .trap_irq_i(trap_irq),
      .trap_code_i(trap_code), .trap_addr_i(trap_addr), .trap_pc_i(trap_pc),
      .resv_set_i(resv_set), .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
      .redirect_o(redirect), .next_pc_o(next_pc), .priv_o(priv), .status_o(status),
      .m_cause_o(m_cause), .m_epc_o(m_epc), .m_tval_o(m_tval),
      .s_cause_o(s_cause), .s_epc_o(s_epc), .s_tval_o(s_tval), .resv_o(resv));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] sel, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 0;
   endtask

   initial begin
      #(20 * 100000);
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [31:0] em_epc, es_epc, em_cause, es_cause, em_tval, es_tval, tv, epc_x;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk("R1 priv", {30'd0, priv}, 32'd3);
      chk("R1 status", {25'd0, status}, 32'd0);
      chk("R1 m_cause", m_cause, 0);
      chk("R1 s_epc", s_epc, 0);
      chk("R1 resv", {31'd0, resv}, 0);
      em_epc = 0; es_epc = 0; em_cause = 0; es_cause = 0; em_tval = 0; es_tval = 0;

      // R10 setup through the write port
      wr(3'd1, 32'h0000_2104);   // exceptions 2, 8, 13 delegated
      wr(3'd2, 32'h0000_0020);   // interrupt 5 delegated
      wr(3'd3, MVEC);
      wr(3'd4, SVEC);

      for (int i = 0; i < NV; i++) begin
         logic [1:0] vp; logic virq, vtos, vcap; logic [5:0] vcode, vecode;
         {vp, virq, vcode, vtos, vecode, vcap} = VEC[i];
         wr(3'd5, {30'd0, vp});
         wr(3'd0, 32'h0000_0003);
         @(negedge clk);
         trap_valid = 1; trap_irq = virq; trap_code = vcode;
         trap_addr = 32'hBAD0_0000 + i; trap_pc = 32'h4000_0000 + i * 16;
         #2;
         tv = vtos ? SVEC : MVEC;
         epc_x = {tv[31:2], 2'b00};
         if (virq && tv[1:0] == 2'b01) epc_x = epc_x + {24'd0, vecode, 2'b00};
         chk($sformatf("R6 next_pc v%0d", i), next_pc, epc_x);
         chk($sformatf("R6 redirect v%0d", i), {31'd0, redirect}, 1);
         @(negedge clk);
         trap_valid = 0;
         if (vtos) begin
            es_epc = trap_pc; es_cause = {virq, 25'd0, vecode};
            es_tval = vcap ? trap_addr : 0;
            chk($sformatf("R2 R4 priv v%0d", i), {30'd0, priv}, 1);
            chk($sformatf("R4 status v%0d", i), {25'd0, status}, {25'd0, 2'b00, vp[0], 1'b0, 1'b1, 1'b1, 1'b0});
         end else begin
            em_epc = trap_pc; em_cause = {virq, 25'd0, vecode};
            em_tval = vcap ? trap_addr : 0;
            chk($sformatf("R2 R3 priv v%0d", i), {30'd0, priv}, 3);
            chk($sformatf("R3 status v%0d", i), {25'd0, status}, {25'd0, vp, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1});
         end
         chk($sformatf("R3 m_epc v%0d", i), m_epc, em_epc);
         chk($sformatf("R4 s_epc v%0d", i), s_epc, es_epc);
         chk($sformatf("R5 R8 m_cause v%0d", i), m_cause, em_cause);
         chk($sformatf("R5 R8 s_cause v%0d", i), s_cause, es_cause);
         chk($sformatf("R7 m_tval v%0d", i), m_tval, em_tval);
         chk($sformatf("R7 s_tval v%0d", i), s_tval, es_tval);
      end

      // R10 privilege value 2 stores user
      wr(3'd5, 32'd2);
      chk("R10 priv2", {30'd0, priv}, 0);

      // R10 trap overrides a write in the same cycle
      @(negedge clk);
      trap_valid = 1; trap_irq = 0; trap_code = 6'd3; trap_pc = 32'h5000_0000;
      wr_en = 1; wr_sel = 3'd5; wr_data = 32'd1;
      @(negedge clk);
      trap_valid = 0; wr_en = 0;
      chk("R10 trap wins priv", {30'd0, priv}, 3);

      // R9 reservation
      @(negedge clk); resv_set = 1;
      @(negedge clk); resv_set = 0;
      chk("R9 resv set", {31'd0, resv}, 1);
      @(negedge clk); trap_valid = 1; trap_code = 6'd3;
      @(negedge clk); trap_valid = 0;
      chk("R9 resv cleared", {31'd0, resv}, 0);
      @(negedge clk); trap_valid = 1; resv_set = 1;
      @(negedge clk); trap_valid = 0; resv_set = 0;
      chk("R9 trap beats set", {31'd0, resv}, 0);

      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule